// File: doc/BRIEF.md
# Shallow-Water Transport Step Datapath

This block advances one horizontal mass-transport component of a depth-averaged ocean model by one explicit time step at a single grid cell. Each cycle it can take one cell's operands:

- the centre transport and its four orthogonal neighbours;
- the crossing transport component at the same cell;
- per-cell coefficients for reciprocal depth, Coriolis and depth-scaled gravity;
- the two surface elevations that bracket the cell along the transport axis;
- a lateral viscosity weight;
- a net forcing term.

It sums a non-linear advection term, a Coriolis term, a pressure-gradient term, a viscous Laplacian and the forcing into a tendency. It scales the tendency by a power-of-two time step and adds it to the centre value. The updated transport appears a fixed number of cycles later.

Central-difference halving and grid-spacing factors are assumed to be folded into the per-cell coefficients upstream. The datapath therefore needs only multiplies, adds and arithmetic shifts. A grid sweep streams cells in back to back. The caller collects results in the same order, four cycles behind.

Top module: `sw_transport_step`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first result, `out_valid` is 0 and `out_u` is 0.
- R2: A cell presented with `in_valid` high at a rising edge produces `out_valid` high exactly 4 rising edges later. A new cell may be accepted every cycle, and results leave in input order.
- R3: When `out_valid` is low, `out_u` keeps its previous value.
- R4: All operands are W-bit two's-complement fixed point with F fractional bits, and every product is shifted right arithmetically by F (rounding toward minus infinity). The advection part of the tendency is `-((( (rdep*u_c)>>>F ) * (u_e-u_w)) >>> F)`.
- R5: The Coriolis part of the tendency is `+((fcor*v_c)>>>F)`.
- R6: The pressure part of the tendency is `-((ghc*(eta_e-eta_w))>>>F)`.
- R7: The viscous part of the tendency is `+((visc*(u_e+u_w+u_n+u_s-4*u_c))>>>F)`.
- R8: `wind` is added to the tendency unscaled.
- R9: Before limiting, the result is `u_c + (tendency >>> DT_SHIFT)`, with rounding toward minus infinity. A negative tendency always moves the result down by at least one LSB when it is nonzero.
- R10: The result is clamped to the W-bit signed range, [-2^(W-1), 2^(W-1)-1]. A tendency that is zero or positive never gives a result below `u_c`, and a negative one never gives a result above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands for one cell are present |
| u_c | input | W | Centre transport |
| u_w | input | W | Transport at i-1 |
| u_e | input | W | Transport at i+1 |
| u_s | input | W | Transport at j-1 |
| u_n | input | W | Transport at j+1 |
| v_c | input | W | Crossing transport at the centre |
| rdep | input | W | Reciprocal depth coefficient |
| fcor | input | W | Coriolis coefficient |
| ghc | input | W | Depth-scaled gravity coefficient |
| eta_w | input | W | Elevation at i-1 |
| eta_e | input | W | Elevation at i+1 |
| wind | input | W | Net forcing |
| visc | input | W | Lateral viscosity weight |
| out_valid | output | 1 | Updated transport is present |
| out_u | output | W | Updated centre transport |

## Verification
A wrong stage register or enable shows as a result that differs from the bit-exact model. It also shows as `out_valid` arriving earlier or later than four cycles after the cell entered. A term with a wrong sign or a wrong shift shows up only on vectors where that term is the one nonzero part. For that reason, each term gets its own isolated vector alongside the random back-to-back stream. A stale output register shows during idle gaps as `out_u` moving without `out_valid`. Clamp faults show on the very first result that exceeds the range.

// File: rtl/sw_transport_step.sv
module sw_transport_step #(
  parameter int W        = 24,
  parameter int F        = 16,
  parameter int DT_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] u_c,
  input  logic signed [W-1:0] u_w,
  input  logic signed [W-1:0] u_e,
  input  logic signed [W-1:0] u_s,
  input  logic signed [W-1:0] u_n,
  input  logic signed [W-1:0] v_c,
  input  logic signed [W-1:0] rdep,
  input  logic signed [W-1:0] fcor,
  input  logic signed [W-1:0] ghc,
  input  logic signed [W-1:0] eta_w,
  input  logic signed [W-1:0] eta_e,
  input  logic signed [W-1:0] wind,
  input  logic signed [W-1:0] visc,
  output logic                out_valid,
  output logic signed [W-1:0] out_u
);

  localparam int SW = 3 * W + 4;
  localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic v1_q, v2_q, v3_q;

  // stage 1: first advection product and differences
  logic signed [SW-1:0] p1_d, dew_d, deta_d, lap_d;
  logic signed [SW-1:0] p1_q, dew_q, deta_q, lap_q;
  logic signed [W-1:0]  uc1_q, vc1_q, cor1_q, gh1_q, vis1_q, wnd1_q;

  assign p1_d   = (SW'(rdep) * SW'(u_c)) >>> F;
  assign dew_d  = SW'(u_e) - SW'(u_w);
  assign deta_d = SW'(eta_e) - SW'(eta_w);
  assign lap_d  = SW'(u_e) + SW'(u_w) + SW'(u_n) + SW'(u_s) - (SW'(u_c) <<< 2);

  always_ff @(posedge clk) begin
    if (in_valid) begin
      p1_q   <= p1_d;
      dew_q  <= dew_d;
      deta_q <= deta_d;
      lap_q  <= lap_d;
      uc1_q  <= u_c;
      vc1_q  <= v_c;
      cor1_q <= fcor;
      gh1_q  <= ghc;
      vis1_q <= visc;
      wnd1_q <= wind;
    end
  end

  // stage 2: the four term products
  logic signed [SW-1:0] adv_d, cor_d, prs_d, vis_d;
  logic signed [SW-1:0] adv_q, cor_q, prs_q, vis_q;
  logic signed [W-1:0]  uc2_q, wnd2_q;

  assign adv_d = (p1_q * dew_q) >>> F;
  assign cor_d = (SW'(cor1_q) * SW'(vc1_q)) >>> F;
  assign prs_d = (SW'(gh1_q) * deta_q) >>> F;
  assign vis_d = (SW'(vis1_q) * lap_q) >>> F;

  always_ff @(posedge clk) begin
    if (v1_q) begin
      adv_q  <= adv_d;
      cor_q  <= cor_d;
      prs_q  <= prs_d;
      vis_q  <= vis_d;
      uc2_q  <= uc1_q;
      wnd2_q <= wnd1_q;
    end
  end

  // stage 3: tendency
  logic signed [SW-1:0] tend_d, tend3_q;
  logic signed [W-1:0]  uc3_q;

  assign tend_d = SW'(wnd2_q) - adv_q + cor_q - prs_q + vis_q;

  always_ff @(posedge clk) begin
    if (v2_q) begin
      tend3_q <= tend_d;
      uc3_q   <= uc2_q;
    end
  end

  // stage 4: time step and clamp
  logic signed [SW-1:0] nxt;
  logic signed [W-1:0]  lim;

  assign nxt = SW'(uc3_q) + (tend3_q >>> DT_SHIFT);
  assign lim = (nxt > MAXV) ? MAXV[W-1:0] :
               (nxt < MINV) ? MINV[W-1:0] : nxt[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      v3_q      <= 1'b0;
      out_valid <= 1'b0;
      out_u     <= '0;
    end else begin
      v1_q      <= in_valid;
      v2_q      <= v1_q;
      v3_q      <= v2_q;
      out_valid <= v3_q;
      if (v3_q) out_u <= lim;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_u)); // R3
  AST_RISE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (v3_q && tend3_q >= 0) |=> (out_u >= $past(uc3_q))); // R10
  AST_FALL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (v3_q && tend3_q < 0) |=> (out_u <= $past(uc3_q))); // R10

endmodule

// File: tb/test_sw_transport_step.sv
module test_sw_transport_step;
  localparam int W = 24;
  localparam int F = 16;
  localparam int DT = 4;
  localparam int CLK_PERIOD = 10;
  localparam longint MAXL = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINL = -(64'sd1 <<< (W-1));

  typedef struct {
    longint uc, uw, ue, us, un, vc, rh, cor, gh, ew, ee, tau, vs;
  } cell_t;
  typedef struct {
    longint exp;
    longint stamp;
    string  tag;
  } item_t;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic signed [W-1:0] u_c = 0, u_w = 0, u_e = 0, u_s = 0, u_n = 0, v_c = 0;
  logic signed [W-1:0] rdep = 0, fcor = 0, ghc = 0, eta_w = 0, eta_e = 0, wind = 0, visc = 0;
  logic out_valid;
  logic signed [W-1:0] out_u;

  int errors = 0, checks = 0;
  longint cyc = 0;
  item_t q[$];
  logic signed [W-1:0] prev_u = 0;
  bit done = 0;

  sw_transport_step #(.W(W), .F(F), .DT_SHIFT(DT)) i_sw_transport_step (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .u_c(u_c), .u_w(u_w), .u_e(u_e), .u_s(u_s), .u_n(u_n), .v_c(v_c),
    .rdep(rdep), .fcor(fcor), .ghc(ghc), .eta_w(eta_w), .eta_e(eta_e),
    .wind(wind), .visc(visc), .out_valid(out_valid), .out_u(out_u));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint model(cell_t c);
    longint p1, adv, cr, pr, vv, t, n;
    p1  = (c.rh * c.uc) >>> F;
    adv = (p1 * (c.ue - c.uw)) >>> F;
    cr  = (c.cor * c.vc) >>> F;
    pr  = (c.gh * (c.ee - c.ew)) >>> F;
    vv  = (c.vs * (c.ue + c.uw + c.un + c.us - 4 * c.uc)) >>> F;
    t   = c.tau - adv + cr - pr + vv;
    n   = c.uc + (t >>> DT);
    if (n > MAXL) n = MAXL;
    if (n < MINL) n = MINL;
    return n;
  endfunction

  function automatic cell_t zero_cell();
    cell_t c;
    c = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    return c;
  endfunction

  function automatic longint rnd(longint r);
    return longint'($urandom_range(0, 32'(2 * r))) - r;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(cell_t c, string tag);
    item_t it;
    @(negedge clk);
    u_c = W'(c.uc); u_w = W'(c.uw); u_e = W'(c.ue); u_s = W'(c.us); u_n = W'(c.un);
    v_c = W'(c.vc); rdep = W'(c.rh); fcor = W'(c.cor); ghc = W'(c.gh);
    eta_w = W'(c.ew); eta_e = W'(c.ee); wind = W'(c.tau); visc = W'(c.vs);
    in_valid = 1;
    it.exp = model(c);
    it.stamp = cyc + 4;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
      u_c = '1; wind = '1;
    end
  endtask

  // monitor: pops expected items, checks value and arrival cycle; checks hold when idle
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check("R2 unexpected result", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(it.tag, longint'(out_u), it.exp);
        check("R2 arrival cycle", cyc, it.stamp);
      end
    end else if (rst_n && !out_valid) begin
      check("R3 hold while idle", longint'(out_u), longint'(prev_u));
    end
    prev_u = out_u;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cell_t c;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 out_u in reset", longint'(out_u), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_u after reset", longint'(out_u), 0);

    c = zero_cell(); c.uc = 12345;
    drive(c, "R9 zero tendency keeps centre");
    c = zero_cell(); c.uc = 32768; c.rh = 65536; c.ue = 16384; c.uw = -16384; c.un = 0; c.us = 0;
    drive(c, "R4 advection only");
    c = zero_cell(); c.cor = 6000; c.vc = 700000;
    drive(c, "R5 coriolis only");
    c = zero_cell(); c.gh = 200000; c.ee = 3000; c.ew = -1000;
    drive(c, "R6 pressure only");
    c = zero_cell(); c.vs = 4000; c.uc = 1000; c.ue = 90000; c.uw = 50000; c.un = -20000; c.us = 7000;
    drive(c, "R7 viscosity only");
    c = zero_cell(); c.tau = 160003;
    drive(c, "R8 forcing only");
    c = zero_cell(); c.uc = 500; c.tau = -1;
    drive(c, "R9 floor of negative step");
    c = zero_cell(); c.uc = MAXL; c.tau = 1 <<< 22;
    drive(c, "R10 clamp high");
    c = zero_cell(); c.uc = MINL; c.tau = -(1 <<< 22);
    drive(c, "R10 clamp low");
    idle(8);

    for (int k = 0; k < 60; k++) begin
      c.uc = rnd(1 <<< 20); c.uw = rnd(1 <<< 20); c.ue = rnd(1 <<< 20);
      c.us = rnd(1 <<< 20); c.un = rnd(1 <<< 20); c.vc = rnd(1 <<< 20);
      c.rh = longint'($urandom_range(0, 65536)); c.cor = rnd(1 <<< 10);
      c.gh = rnd(1 <<< 18); c.ew = rnd(1 <<< 12); c.ee = rnd(1 <<< 12);
      c.tau = rnd(1 <<< 18); c.vs = longint'($urandom_range(0, 4096));
      drive(c, "R2 R4 R5 R6 R7 R8 R9 R10 random stream");
      if (k % 7 == 6) idle(k % 3 + 1);
    end
    idle(10);
    check("R2 all results delivered", longint'(q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule